// File: doc/BRIEF.md
# Sixteen-Lane Marker Lock, Deskew and Reorder

This block sits on the receive side of a link whose sixteen logical lanes reach the host on arbitrary physical inputs, each delayed by its own unknown skew. Every logical lane carries a marker word every `PERIOD` words, and the marker holds that lane's identifier. Each physical input has a lock machine that finds the marker cadence and records the identifier it carries.

Once all sixteen inputs are locked, the control side measures the relative marker phases and loads a per-lane delay into a tapped history buffer, so that all markers leave the buffers in the same cycle. It also loads a routing table that sends each deskewed input to the output slot named by its identifier. An aligned status is raised only after the deskewed markers are seen to coincide. The downstream de-interleaver reads `laneOut` only while `aligned` is high.

A marker word has `0xA5` in bits [15:8] and the lane identifier in bits [7:0]. Any other upper byte is payload.

Top module: `mlLaneAligner`

## Requirements
- R1: A physical lane reports locked in the cycle after the second of two markers that have the same identifier and are exactly `PERIOD` (128) words apart. It is not locked before that cycle.
- R2: A locked lane keeps its lock through one or two consecutive expected marker slots that are missing or carry a different identifier. It loses lock on the third consecutive such slot.
- R3: After alignment, output slot j at the sample after clock edge e carries the word that logical lane j produced at stream time e − 4 − Smax. Here a physical input with skew s presents stream time e − 4 − s at edge e, and Smax is the largest skew among the inputs.
- R4: Each output slot j carries the deskewed input whose locked marker identifier equals j, for any permutation of logical lanes over physical inputs.
- R5: `aligned` rises only when all sixteen lanes are locked, the identifiers are valid, and the deskewed markers of all sixteen lanes appear in the same cycle.
- R6: If the marker phase spread between the earliest and latest lanes exceeds `DEPTH` (32) words, `skewErr` is set and `aligned` stays low. A spread of exactly 32 words aligns normally with `skewErr` low.
- R7: If, with all lanes locked, any identifier is 16 or larger or two lanes share an identifier, `idErr` is set and `aligned` stays low. `idErr` remains set until reset, even after the identifiers become valid.
- R8: During and right after reset, `aligned`, `skewErr`, `idErr`, `laneLocked` and `laneOut` are all zero.
- R9: `aligned` falls once any lane loses lock, and stays high while lanes only miss fewer than three markers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| laneIn | input | 256 | Sixteen physical lane words, lane p at bits [16p+15:16p] |
| laneOut | output | 256 | Sixteen deskewed words in logical order, slot j at bits [16j+15:16j] |
| laneLocked | output | 16 | Per physical lane lock status |
| aligned | output | 1 | All lanes locked, deskewed and routed |
| skewErr | output | 1 | Measured marker spread exceeds the buffer depth |
| idErr | output | 1 | Sticky: duplicate or out-of-range identifier seen |

## Verification
The bench applies shuffled lane permutations with skew spreads from zero up to exactly the buffer depth. A delay computed with the wrong sign or off by one would shift payload words by a fixed count, and a routing table inverted from physical to logical would put words in the wrong output slot. Both faults show up as payload miscompares against the reconstructed stream. One lane exceeds the depth by a single word to catch an inclusive-versus-exclusive limit check. Marker drop-outs of exactly two and three slots separate a miss counter that trips early from one that never trips. A duplicated identifier that is later repaired without a reset exposes an error flag that clears itself when it should stay set.

// File: rtl/mlPkg.sv
`timescale 1ns/1ps
package mlPkg;

  typedef enum logic [1:0] {
    LK_HUNT,
    LK_CONFIRM,
    LK_LOCKED
  } lockSt_e;

  typedef enum logic [1:0] {
    AL_WAIT,
    AL_CHECK,
    AL_DONE
  } alignSt_e;

  typedef struct packed {
    logic loadDelay;
    logic loadRoute;
  } ctrlStrb_t;

endpackage

// File: rtl/mlLaneLock.sv
`timescale 1ns/1ps
module mlLaneLock
  import mlPkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int ID_W       = 8,
  parameter int PERIOD     = 128,
  parameter int MISS_LIMIT = 3,
  parameter logic [WORD_W-ID_W-1:0] MARK_PAT = 'hA5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [WORD_W-1:0]           wordIn,
  output logic                        locked,
  output logic [ID_W-1:0]             lockId,
  output logic [$clog2(PERIOD)-1:0]   phase
);

  localparam int PAT_W  = WORD_W - ID_W;
  localparam int CNT_W  = $clog2(PERIOD);
  localparam int MISS_W = $clog2(MISS_LIMIT + 1);

  lockSt_e             stQ;
  logic [CNT_W-1:0]    cntQ;
  logic [ID_W-1:0]     idQ;
  logic [MISS_W-1:0]   missQ;

  logic                isMark;
  logic [ID_W-1:0]     rxId;
  logic                atSlot;
  logic                goodMark;

  assign isMark   = (wordIn[WORD_W-1 -: PAT_W] == MARK_PAT);
  assign rxId     = wordIn[ID_W-1:0];
  assign atSlot   = (cntQ == '0);
  assign goodMark = isMark && (rxId == idQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      stQ   <= LK_HUNT;
      cntQ  <= '0;
      idQ   <= '0;
      missQ <= '0;
    end else begin
      cntQ <= cntQ + CNT_W'(1);
      unique case (stQ)
        LK_HUNT: begin
          if (isMark) begin
            stQ  <= LK_CONFIRM;
            cntQ <= CNT_W'(1);
            idQ  <= rxId;
          end
        end
        LK_CONFIRM: begin
          if (atSlot) begin
            if (goodMark) begin
              stQ   <= LK_LOCKED;
              missQ <= '0;
            end else if (isMark) begin
              idQ <= rxId;
            end else begin
              stQ <= LK_HUNT;
            end
          end
        end
        LK_LOCKED: begin
          if (atSlot) begin
            if (goodMark) begin
              missQ <= '0;
            end else if (missQ == MISS_W'(MISS_LIMIT - 1)) begin
              stQ   <= LK_HUNT;
              missQ <= '0;
            end else begin
              missQ <= missQ + MISS_W'(1);
            end
          end
        end
        default: stQ <= LK_HUNT;
      endcase
    end
  end

  assign locked = (stQ == LK_LOCKED);
  assign lockId = idQ;
  assign phase  = cntQ;

  // R1: lock is only gained on a matching marker at the expected slot
  p_lock_on_mark_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(goodMark));

  // R2: lock is only dropped on a bad expected slot
  p_unlock_on_miss_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(!goodMark));

endmodule

// File: rtl/mlAlignCtrl.sv
`timescale 1ns/1ps
module mlAlignCtrl
  import mlPkg::*;
#(
  parameter int LANES  = 16,
  parameter int ID_W   = 8,
  parameter int PERIOD = 128,
  parameter int DEPTH  = 32
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic [LANES-1:0]                        lockedV,
  input  logic [LANES-1:0][ID_W-1:0]              idV,
  input  logic [LANES-1:0][$clog2(PERIOD)-1:0]    phaseV,
  input  logic                                    anyDlyMark,
  input  logic                                    allDlyMark,
  output ctrlStrb_t                               strb,
  output logic [LANES-1:0][$clog2(DEPTH+1)-1:0]   delayCalc,
  output logic [LANES-1:0][$clog2(LANES)-1:0]     routeCalc,
  output logic                                    aligned,
  output logic                                    skewErr,
  output logic                                    idErr
);

  localparam int CNT_W = $clog2(PERIOD);
  localparam int DLY_W = $clog2(DEPTH + 1);
  localparam int SEL_W = $clog2(LANES);

  alignSt_e stQ;
  logic     skewErrQ;
  logic     idErrQ;
  logic     allLocked;

  int   relV [LANES];
  int   minRel;
  int   maxRel;
  logic skewBad;
  logic idBad;

  assign allLocked = &lockedV;

  // Relative marker phase of each lane against lane 0, signed within half a period
  always_comb begin
    logic [CNT_W-1:0] diff;
    minRel = 0;
    maxRel = 0;
    for (int i = 0; i < LANES; i++) begin
      diff    = phaseV[i] - phaseV[0];
      relV[i] = int'($signed(diff));
      if (relV[i] < minRel) minRel = relV[i];
      if (relV[i] > maxRel) maxRel = relV[i];
    end
    skewBad = (maxRel - minRel) > DEPTH;
    for (int i = 0; i < LANES; i++) begin
      delayCalc[i] = DLY_W'(relV[i] - minRel);
    end
  end

  // Identifier checks and logical-to-physical route table
  always_comb begin
    int   hits;
    logic outRange;
    logic dup;
    logic missing;
    outRange = 1'b0;
    dup      = 1'b0;
    missing  = 1'b0;
    for (int p = 0; p < LANES; p++) begin
      if (idV[p] >= ID_W'(LANES)) outRange = 1'b1;
    end
    for (int j = 0; j < LANES; j++) begin
      hits         = 0;
      routeCalc[j] = '0;
      for (int p = 0; p < LANES; p++) begin
        if (idV[p] == ID_W'(j)) begin
          hits++;
          routeCalc[j] = SEL_W'(p);
        end
      end
      if (hits == 0) missing = 1'b1;
      if (hits > 1)  dup     = 1'b1;
    end
    idBad = outRange || dup || missing;
  end

  always_comb begin
    strb.loadDelay = (stQ == AL_WAIT) && allLocked && !idErrQ && !idBad && !skewBad;
    strb.loadRoute = strb.loadDelay;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stQ      <= AL_WAIT;
      skewErrQ <= 1'b0;
      idErrQ   <= 1'b0;
    end else begin
      unique case (stQ)
        AL_WAIT: begin
          if (allLocked && !idErrQ) begin
            if (idBad) begin
              idErrQ <= 1'b1;
            end else if (skewBad) begin
              skewErrQ <= 1'b1;
            end else begin
              skewErrQ <= 1'b0;
              stQ      <= AL_CHECK;
            end
          end
        end
        AL_CHECK: begin
          if (!allLocked) begin
            stQ <= AL_WAIT;
          end else if (anyDlyMark) begin
            stQ <= allDlyMark ? AL_DONE : AL_WAIT;
          end
        end
        AL_DONE: begin
          if (!allLocked) stQ <= AL_WAIT;
        end
        default: stQ <= AL_WAIT;
      endcase
    end
  end

  assign aligned = (stQ == AL_DONE);
  assign skewErr = skewErrQ;
  assign idErr   = idErrQ;

  // R5: aligned implies every lane was locked in the previous cycle
  p_aligned_locked_r5: assert property (@(posedge clk) disable iff (rst)
    aligned |-> $past(allLocked));

  // R5: aligned is entered only on coincident deskewed markers
  p_enter_coincide_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(aligned) |-> $past(allDlyMark));

  // R6: a skew fault keeps aligned low
  p_skew_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    skewErr |-> !aligned);

  // R7: identifier fault keeps aligned low and is sticky
  p_id_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    idErr |-> !aligned);

  p_id_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    idErr |=> idErr);

  // R9: losing any lock takes aligned down on the next edge
  p_drop_on_unlock_r9: assert property (@(posedge clk) disable iff (rst)
    (aligned && !allLocked) |=> !aligned);

endmodule

// File: rtl/mlDeskewPath.sv
`timescale 1ns/1ps
module mlDeskewPath
  import mlPkg::*;
#(
  parameter int LANES  = 16,
  parameter int WORD_W = 16,
  parameter int ID_W   = 8,
  parameter int DEPTH  = 32,
  parameter logic [WORD_W-ID_W-1:0] MARK_PAT = 'hA5
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [LANES-1:0][WORD_W-1:0]           laneIn,
  input  ctrlStrb_t                              strb,
  input  logic [LANES-1:0][$clog2(DEPTH+1)-1:0]  delayCalc,
  input  logic [LANES-1:0][$clog2(LANES)-1:0]    routeCalc,
  output logic [LANES-1:0][WORD_W-1:0]           laneOut,
  output logic                                   anyDlyMark,
  output logic                                   allDlyMark
);

  localparam int PAT_W = WORD_W - ID_W;
  localparam int DLY_W = $clog2(DEPTH + 1);
  localparam int SEL_W = $clog2(LANES);
  localparam int HIX_W = $clog2(DEPTH);

  logic [LANES-1:0][DLY_W-1:0]  delayQ;
  logic [LANES-1:0][SEL_W-1:0]  routeQ;
  logic [LANES-1:0][WORD_W-1:0] dly;
  logic [LANES-1:0]             dlyMark;
  logic [LANES-1:0][WORD_W-1:0] outQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      delayQ <= '0;
      routeQ <= '0;
    end else begin
      if (strb.loadDelay) delayQ <= delayCalc;
      if (strb.loadRoute) routeQ <= routeCalc;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WORD_W-1:0] hist [DEPTH];
    logic [HIX_W-1:0]  tap;

    always_ff @(posedge clk) begin
      hist[0] <= laneIn[g];
      for (int k = 1; k < DEPTH; k++) hist[k] <= hist[k-1];
    end

    assign tap        = HIX_W'(delayQ[g] - DLY_W'(1));
    assign dly[g]     = (delayQ[g] == '0) ? laneIn[g] : hist[tap];
    assign dlyMark[g] = (dly[g][WORD_W-1 -: PAT_W] == MARK_PAT);

    // R6: an applied delay never reaches past the end of the buffer
    p_delay_bound_r6: assert property (@(posedge clk) disable iff (rst)
      delayQ[g] <= DLY_W'(DEPTH));
  end

  assign anyDlyMark = |dlyMark;
  assign allDlyMark = &dlyMark;

  always_ff @(posedge clk) begin
    if (rst) begin
      outQ <= '0;
    end else begin
      for (int j = 0; j < LANES; j++) outQ[j] <= dly[routeQ[j]];
    end
  end

  assign laneOut = outQ;

  // R8: output register is clear on the first edge after reset
  p_out_clear_r8: assert property (@(posedge clk)
    $past(rst) |-> (laneOut == '0));

endmodule

// File: rtl/mlLaneAligner.sv
`timescale 1ns/1ps
module mlLaneAligner
  import mlPkg::*;
#(
  parameter int LANES  = 16,
  parameter int WORD_W = 16,
  parameter int ID_W   = 8,
  parameter int PERIOD = 128,
  parameter int DEPTH  = 32,
  parameter int MISS_LIMIT = 3,
  parameter logic [WORD_W-ID_W-1:0] MARK_PAT = 'hA5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LANES*WORD_W-1:0]   laneIn,
  output logic [LANES*WORD_W-1:0]   laneOut,
  output logic [LANES-1:0]          laneLocked,
  output logic                      aligned,
  output logic                      skewErr,
  output logic                      idErr
);

  localparam int CNT_W = $clog2(PERIOD);
  localparam int DLY_W = $clog2(DEPTH + 1);
  localparam int SEL_W = $clog2(LANES);

  logic [LANES-1:0][WORD_W-1:0] inV;
  logic [LANES-1:0][WORD_W-1:0] outV;
  logic [LANES-1:0][ID_W-1:0]   idV;
  logic [LANES-1:0][CNT_W-1:0]  phaseV;
  logic [LANES-1:0]             lockedV;
  logic [LANES-1:0][DLY_W-1:0]  delayCalc;
  logic [LANES-1:0][SEL_W-1:0]  routeCalc;
  logic                         anyDlyMark;
  logic                         allDlyMark;
  ctrlStrb_t                    strb;

  assign inV = laneIn;

  for (genvar p = 0; p < LANES; p++) begin : g_lock
    mlLaneLock #(
      .WORD_W(WORD_W), .ID_W(ID_W), .PERIOD(PERIOD),
      .MISS_LIMIT(MISS_LIMIT), .MARK_PAT(MARK_PAT)
    ) uLock (
      .clk(clk), .rst(rst), .wordIn(inV[p]),
      .locked(lockedV[p]), .lockId(idV[p]), .phase(phaseV[p])
    );
  end

  mlAlignCtrl #(
    .LANES(LANES), .ID_W(ID_W), .PERIOD(PERIOD), .DEPTH(DEPTH)
  ) uCtrl (
    .clk(clk), .rst(rst), .lockedV(lockedV), .idV(idV), .phaseV(phaseV),
    .anyDlyMark(anyDlyMark), .allDlyMark(allDlyMark), .strb(strb),
    .delayCalc(delayCalc), .routeCalc(routeCalc),
    .aligned(aligned), .skewErr(skewErr), .idErr(idErr)
  );

  mlDeskewPath #(
    .LANES(LANES), .WORD_W(WORD_W), .ID_W(ID_W), .DEPTH(DEPTH), .MARK_PAT(MARK_PAT)
  ) uPath (
    .clk(clk), .rst(rst), .laneIn(inV), .strb(strb),
    .delayCalc(delayCalc), .routeCalc(routeCalc), .laneOut(outV),
    .anyDlyMark(anyDlyMark), .allDlyMark(allDlyMark)
  );

  assign laneOut    = outV;
  assign laneLocked = lockedV;

endmodule

// File: tb/tb_mlLaneAligner.sv
`timescale 1ns/1ps
module tb_mlLaneAligner;

  localparam int LANES = 16;
  localparam int WW    = 16;
  localparam int P     = 128;
  localparam int DEPTH = 32;
  localparam int LAT0  = 4;
  localparam int NVEC  = 5;
  localparam int VEC_SEED [NVEC] = '{11, 237, 4049, 777, 90210};
  localparam int VEC_SPAN [NVEC] = '{0, 7, 19, 31, 32};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                  rst;
  logic [LANES*WW-1:0]   laneIn;
  logic [LANES*WW-1:0]   laneOut;
  logic [LANES-1:0]      laneLocked;
  logic                  aligned, skewErr, idErr;

  mlLaneAligner dut (
    .clk(clk), .rst(rst), .laneIn(laneIn), .laneOut(laneOut),
    .laneLocked(laneLocked), .aligned(aligned), .skewErr(skewErr), .idErr(idErr)
  );

  int          edgeN;
  int          checks = 0;
  int          fails  = 0;
  int          perm [LANES];
  int          skew [LANES];
  logic [7:0]  idOf [LANES];
  int          badPhys = -1;
  int          badFrom = 0;
  int          badCount = 0;
  int unsigned lcg;

  function automatic logic [15:0] wordOf(int j, int t, logic [7:0] id);
    if (t >= 0 && (t % P) == 0) return {8'hA5, id};
    return {4'h0, 4'(j), 8'(t)};
  endfunction

  function automatic int rnd(int n);
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'((lcg >> 16) % n);
  endfunction

  // stimulus generator: physical lane p carries logical lane perm[p], delayed by skew[p]
  initial begin
    edgeN  = 0;
    laneIn = '0;
    forever begin
      @(posedge clk);
      if (rst) edgeN = 0; else edgeN++;
      @(negedge clk);
      for (int p = 0; p < LANES; p++) begin
        int t;
        logic [15:0] w;
        t = edgeN + 1 - LAT0 - skew[p];
        w = wordOf(perm[p], t, idOf[perm[p]]);
        if (p == badPhys && t >= 0 && (t % P) == 0 &&
            (t / P) >= badFrom && (t / P) < badFrom + badCount)
          w = {4'h0, 4'(perm[p]), 8'(t)};
        laneIn[p*WW +: WW] = w;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic setup(input int seed, input int span);
    lcg = seed;
    for (int i = 0; i < LANES; i++) begin
      perm[i] = i;
      idOf[i] = 8'(i);
    end
    for (int i = LANES - 1; i > 0; i--) begin
      int k, tmp;
      k = rnd(i + 1);
      tmp = perm[i]; perm[i] = perm[k]; perm[k] = tmp;
    end
    for (int i = 0; i < LANES; i++) skew[i] = rnd(span + 1);
    skew[0] = 0;
    skew[LANES-1] = span;
  endtask

  task automatic doReset();
    rst = 1'b1;
    badPhys = -1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic waitAligned(output bit got);
    got = 1'b0;
    repeat (3*P + 200) begin
      @(negedge clk);
      if (aligned) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic compareRun(input int smax);
    bit          bad [LANES];
    logic [15:0] fAct [LANES];
    logic [15:0] fExp [LANES];
    for (int j = 0; j < LANES; j++) begin
      bad[j] = 1'b0; fAct[j] = '0; fExp[j] = '0;
    end
    repeat (2*P) begin
      @(negedge clk);
      for (int j = 0; j < LANES; j++) begin
        logic [15:0] e, a;
        e = wordOf(j, edgeN - LAT0 - smax, idOf[j]);
        a = laneOut[j*WW +: WW];
        if (a !== e && !bad[j]) begin
          bad[j] = 1'b1; fAct[j] = a; fExp[j] = e;
        end
      end
    end
    for (int j = 0; j < LANES; j++)
      chk(!bad[j], "R3/R4", $sformatf("slot %0d payload", j), fAct[j], fExp[j]);
  endtask

  task automatic missRun(input int cnt, input bit expLocked);
    bit got;
    int s, target;
    setup(555, 10);
    doReset();
    waitAligned(got);
    chk(got, "R5", "aligned before miss test", got, 1);
    s = skew[3];
    badFrom  = (edgeN - LAT0 - s) / P + 1;
    badCount = cnt;
    badPhys  = 3;
    target = LAT0 + s + (badFrom + 2) * P + 3;
    while (edgeN < target) @(negedge clk);
    chk(laneLocked[3] == expLocked, "R2", $sformatf("lock after %0d misses", cnt),
        laneLocked[3], expLocked);
    chk(aligned == expLocked, "R9", $sformatf("aligned after %0d misses", cnt),
        aligned, expLocked);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    bit got;
    rst = 1'b1;
    setup(1, 0);
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(aligned == 1'b0, "R8", "aligned in reset", aligned, 0);
    chk(skewErr == 1'b0 && idErr == 1'b0, "R8", "errors in reset", {skewErr, idErr}, 0);
    chk(laneLocked == '0, "R8", "locks in reset", laneLocked, 0);
    chk(laneOut == '0, "R8", "outputs in reset", laneOut != '0, 0);

    // R1: lock timing with zero skew, markers at edges 4 and 4+P
    rst = 1'b0;
    while (edgeN < LAT0 + P - 1) @(negedge clk);
    chk(laneLocked == '0, "R1", "lock before second marker", laneLocked, 0);
    @(negedge clk);
    chk(laneLocked == '1, "R1", "lock after second marker", laneLocked, 16'hFFFF);

    // table of permutation and skew vectors
    for (int v = 0; v < NVEC; v++) begin
      setup(VEC_SEED[v], VEC_SPAN[v]);
      doReset();
      waitAligned(got);
      chk(got, "R5", $sformatf("aligned, span %0d", VEC_SPAN[v]), got, 1);
      chk(!skewErr && !idErr, "R6", $sformatf("no error, span %0d", VEC_SPAN[v]),
          {skewErr, idErr}, 0);
      compareRun(VEC_SPAN[v]);
    end

    // R2 / R9: two misses keep lock, three lose it
    missRun(2, 1'b1);
    missRun(3, 1'b0);

    // R6: spread one beyond depth
    setup(3, 0);
    skew[9] = DEPTH + 1;
    doReset();
    repeat (3*P + 100) @(negedge clk);
    chk(skewErr == 1'b1, "R6", "skew error at depth+1", skewErr, 1);
    chk(aligned == 1'b0, "R6", "aligned at depth+1", aligned, 0);

    // R7: duplicate identifier, then repaired without reset
    setup(8, 5);
    idOf[5] = 8'd3;
    doReset();
    repeat (3*P + 100) @(negedge clk);
    chk(idErr == 1'b1, "R7", "duplicate id flag", idErr, 1);
    chk(aligned == 1'b0, "R7", "aligned with duplicate", aligned, 0);
    idOf[5] = 8'd5;
    repeat (6*P) @(negedge clk);
    chk(idErr == 1'b1, "R7", "flag sticky after repair", idErr, 1);
    chk(aligned == 1'b0, "R7", "aligned after repair", aligned, 0);
    doReset();
    @(negedge clk);
    chk(idErr == 1'b0, "R8", "flag cleared by reset", idErr, 0);

    // R7: out-of-range identifier
    setup(21, 4);
    idOf[7] = 8'h20;
    doReset();
    repeat (3*P + 100) @(negedge clk);
    chk(idErr == 1'b1, "R7", "out-of-range id flag", idErr, 1);
    chk(aligned == 1'b0, "R7", "aligned with bad id", aligned, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule